// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves 16-bit words between a drive data port and byte-wide system memory without processor help. Software places a table of 8-byte region entries in memory, writes the table's base address into the engine, sets a direction bit and flips the start bit. The engine reads each table entry (a buffer address, a byte count and a closing flag) and then copies words while the drive raises its request line. When the last buffer of the flagged entry is used up, the engine stops on its own.

Two 32-bit registers face software. Offset 0 carries the command byte in bits 7:0 and the status byte in bits 23:16. Offset 1 carries the table base. Byte enables pick which bytes a write touches. Status holds a running flag and a sticky interrupt flag, which the drive interrupt line sets on a rising edge and software clears by writing one. It also holds two capability flags that software can read and write freely. Memory accesses use a request/acknowledge handshake, one byte per access. The drive side uses one-cycle read and write strobes, each moving one 16-bit word.

Top module: `sgdma_engine`

## Requirements
- R1: A write to offset 0 with byte enable 0 set stores only command bit 0 (start) and bit 3 (direction: 1 means drive-to-memory, 0 means memory-to-drive). Every other command bit reads back 0.
- R2: When the start bit changes from 0 to 1, status bit 0 (running) is set, the remaining count is cleared and the table pointer is reloaded from the base register. The first memory access that follows is a read of the base address.
- R3: When the start bit changes from 1 to 0 while running, status bit 0 clears and no further memory access or drive strobe occurs.
- R4: A status write with byte enable 2 set does three things. Status bits 5 and 6 take the written value. Writing 1 to bit 2 clears the interrupt flag. Bits 0, 1, 3, 4 and 7 ignore the write. Bit 1 (error) always reads 0.
- R5: A table entry is 8 consecutive bytes read in ascending order, least significant byte first. Bytes 0 to 3 form the buffer address with bit 0 forced to 0. Bytes 4 onward hold the byte count in the low LEN_W bits with bit 0 forced to 0. Bit 7 of byte 7 marks the final entry.
- R6: A byte count of zero stands for 2^LEN_W bytes.
- R7: No entry is fetched and no word is started unless the drive request input is high and status bit 0 is set.
- R8: Each word uses two memory bytes, the low byte at the lower, even address. Drive-to-memory reads one word from the drive and then writes the low byte followed by the high byte. Memory-to-drive reads both bytes and then presents the word with one drive write strobe. Each word advances the address by 2 and lowers the count by 2.
- R9: When the count of an entry that is not the final one reaches zero, the next entry is fetched from the 8 bytes that follow.
- R10: When the count of the final entry reaches zero, status bit 0 clears. A drive request still held high afterwards starts no further access and leaves the error bit at 0.
- R11: A write to offset 1 stores the enabled bytes with bits 1:0 forced to 0. Reading offset 1 returns the base. Reading any offset other than 0 or 1 returns all ones.
- R12: A rising edge on the drive interrupt input sets status bit 2. A level held high does not set it again after software clears it.
- R13: Byte enable 0 alone updates only the command byte, and byte enable 2 alone updates only the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | OFF_W | Register word offset |
| reg_be | input | 4 | Byte enables for register writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_off (combinational) |
| mem_req | output | 1 | Memory byte access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| dmarq | input | 1 | Drive requests data movement |
| drv_rd | output | 1 | Strobe: take one word from the drive |
| drv_rdata | input | 16 | Word from the drive, sampled with drv_rd |
| drv_wr | output | 1 | Strobe: give one word to the drive |
| drv_wdata | output | 16 | Word to the drive, valid with drv_wr |
| drv_irq | input | 1 | Drive interrupt line |

## Verification
The bench builds the engine with LEN_W set to 8, so a zero count stands for a 256-byte buffer. This makes it cheap to run the zero-count case, buffers at their full length, and chains of up to five entries with rollover between them. ADDR_W stays at 32 so that the full four-byte address decode is exercised, and OFF_W at 2 so that offsets 2 and 3 reach the all-ones read path. Memory acknowledge delays and the drive request toggle at random, so entry fetches and word beats stall and resume at every step of the sequence.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_FETCH,
        MV_PULL,
        MV_LO,
        MV_HI,
        MV_PUSH
    } mv_state_e;

    localparam int CMD_GO    = 0;
    localparam int CMD_TOMEM = 3;
    localparam int STS_RUN   = 0;
    localparam int STS_INT   = 2;
    localparam int STS_CAP_L = 5;

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [3:0]       reg_be,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             drv_irq,
    input  logic             eot,
    output logic             launch,
    output logic             running,
    output logic             to_mem,
    output logic [31:0]      tbl_base
);

    typedef struct packed {
        logic        go;
        logic        dir;
        logic        run;
        logic        intr;
        logic [1:0]  cap;
        logic        irq_last;
        logic [31:0] base;
    } regs_t;

    regs_t q, d;
    logic  cmd_wr, sts_wr, base_wr;

    always_comb begin
        d       = q;
        launch  = 1'b0;
        cmd_wr  = reg_wr && (reg_off == OFF_W'(0)) && reg_be[0];
        sts_wr  = reg_wr && (reg_off == OFF_W'(0)) && reg_be[2];
        base_wr = reg_wr && (reg_off == OFF_W'(1));

        if (eot) d.run = 1'b0;

        if (cmd_wr) begin
            d.go  = reg_wdata[CMD_GO];
            d.dir = reg_wdata[CMD_TOMEM];
            if (!q.go && reg_wdata[CMD_GO]) begin
                d.run  = 1'b1;
                launch = 1'b1;
            end else if (q.go && !reg_wdata[CMD_GO]) begin
                d.run = 1'b0;
            end
        end

        if (sts_wr) begin
            d.cap = reg_wdata[16+STS_CAP_L +: 2];
            if (reg_wdata[16+STS_INT]) d.intr = 1'b0;
        end

        if (drv_irq && !q.irq_last) d.intr = 1'b1;
        d.irq_last = drv_irq;

        if (base_wr) begin
            for (int b = 0; b < 4; b++) begin
                if (reg_be[b]) d.base[8*b +: 8] = reg_wdata[8*b +: 8];
            end
            d.base[1:0] = 2'b00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_off)
            OFF_W'(0): reg_rdata = {8'h00, 1'b0, q.cap, 2'b00, q.intr, 1'b0, q.run,
                                    8'h00, 4'h0, q.dir, 2'b00, q.go};
            OFF_W'(1): reg_rdata = q.base;
            default:   reg_rdata = '1;
        endcase
    end

    assign running  = q.run;
    assign to_mem   = q.dir;
    assign tbl_base = q.base;

    p_launch_sets_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> q.run);

    p_stop_clears_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && q.go && !reg_wdata[CMD_GO]) |=> !q.run);

    p_cap_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr |=> (q.cap == $past(reg_wdata[22:21])));

    p_end_stops_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eot && !launch) |=> !q.run);

    p_irq_edge_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_irq) |=> q.intr);

endmodule

// File: rtl/sgdma_mover.sv
module sgdma_mover
    import sgdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              running,
    input  logic              to_mem,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              dmarq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              drv_rd,
    input  logic [15:0]       drv_rdata,
    output logic              drv_wr,
    output logic [15:0]       drv_wdata,
    output logic              eot
);

    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] FULL_LEN = {1'b1, {LEN_W{1'b0}}};

    typedef struct packed {
        mv_state_e         st;
        logic [2:0]        idx;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] cur;
        logic [CNT_W-1:0]  cnt;
        logic              last;
        logic [15:0]       word;
        logic [55:0]       ent;
    } mv_t;

    mv_t          q, d;
    logic [63:0]  entry;
    logic [LEN_W-1:0] len_f;
    logic         finish;
    logic         unused_entry;

    assign unused_entry = ^entry;

    always_comb begin
        d         = q;
        eot       = 1'b0;
        finish    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.cur;
        mem_wdata = q.word[7:0];
        drv_rd    = 1'b0;
        drv_wr    = 1'b0;
        drv_wdata = q.word;
        entry     = {mem_rdata, q.ent};
        len_f     = {entry[32+LEN_W-1:33], 1'b0};

        if (launch) begin
            d.st   = MV_IDLE;
            d.cnt  = '0;
            d.ptr  = tbl_base;
            d.last = 1'b0;
        end else if (!running) begin
            d.st = MV_IDLE;
        end else begin
            case (q.st)
                MV_IDLE: begin
                    if (dmarq) begin
                        if (q.cnt == '0) begin
                            d.st  = MV_FETCH;
                            d.idx = '0;
                        end else begin
                            d.st = to_mem ? MV_PULL : MV_LO;
                        end
                    end
                end
                MV_FETCH: begin
                    mem_req  = 1'b1;
                    mem_addr = q.ptr;
                    if (mem_ack) begin
                        d.ptr = q.ptr + ADDR_W'(1);
                        d.idx = q.idx + 3'd1;
                        if (q.idx == 3'd7) begin
                            d.cur  = {entry[ADDR_W-1:1], 1'b0};
                            d.cnt  = (len_f == '0) ? FULL_LEN : {1'b0, len_f};
                            d.last = entry[63];
                            d.st   = MV_IDLE;
                        end else begin
                            d.ent[q.idx*8 +: 8] = mem_rdata;
                        end
                    end
                end
                MV_PULL: begin
                    drv_rd = 1'b1;
                    d.word = drv_rdata;
                    d.st   = MV_LO;
                end
                MV_LO: begin
                    mem_req   = 1'b1;
                    mem_we    = to_mem;
                    mem_wdata = q.word[7:0];
                    if (mem_ack) begin
                        if (!to_mem) d.word[7:0] = mem_rdata;
                        d.cur = q.cur + ADDR_W'(1);
                        d.st  = MV_HI;
                    end
                end
                MV_HI: begin
                    mem_req   = 1'b1;
                    mem_we    = to_mem;
                    mem_wdata = q.word[15:8];
                    if (mem_ack) begin
                        if (!to_mem) d.word[15:8] = mem_rdata;
                        d.cur = q.cur + ADDR_W'(1);
                        if (to_mem) finish = 1'b1;
                        else        d.st   = MV_PUSH;
                    end
                end
                MV_PUSH: begin
                    drv_wr = 1'b1;
                    finish = 1'b1;
                end
                default: d.st = MV_IDLE;
            endcase

            if (finish) begin
                d.cnt = q.cnt - CNT_W'(2);
                d.st  = MV_IDLE;
                if (q.cnt == CNT_W'(2) && q.last) eot = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: MV_IDLE, default: '0};
        else        q <= d;
    end

    p_count_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cnt[0]);

    p_low_byte_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q.st == MV_LO) |-> !mem_addr[0]);

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, drv_rd, drv_wr}));

    p_pull_then_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_rd |=> (q.st == MV_LO));

    p_wait_for_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == MV_IDLE && !dmarq) |=> (q.st == MV_IDLE));

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    input  logic              dmarq,
    output logic              drv_rd,
    input  logic [15:0]       drv_rdata,
    output logic              drv_wr,
    output logic [15:0]       drv_wdata,
    input  logic              drv_irq
);

    logic        launch, running, to_mem, eot;
    logic [31:0] tbl_base;

    sgdma_regs #(.OFF_W(OFF_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_off   (reg_off),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .drv_irq   (drv_irq),
        .eot       (eot),
        .launch    (launch),
        .running   (running),
        .to_mem    (to_mem),
        .tbl_base  (tbl_base)
    );

    sgdma_mover #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .running   (running),
        .to_mem    (to_mem),
        .tbl_base  (tbl_base[ADDR_W-1:0]),
        .dmarq     (dmarq),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .drv_rd    (drv_rd),
        .drv_rdata (drv_rdata),
        .drv_wr    (drv_wr),
        .drv_wdata (drv_wdata),
        .eot       (eot)
    );

endmodule

// File: tb/sgdma_engine_test.sv
module sgdma_engine_test;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;
    localparam int OFF_W  = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [OFF_W-1:0]  reg_off = '0;
    logic [3:0]        reg_be = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              dmarq = 1'b0;
    logic              drv_rd, drv_wr;
    logic [15:0]       drv_rdata, drv_wdata;
    logic              drv_irq = 1'b0;

    sgdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dmarq(dmarq), .drv_rd(drv_rd), .drv_rdata(drv_rdata), .drv_wr(drv_wr),
        .drv_wdata(drv_wdata), .drv_irq(drv_irq)
    );

    // memory and drive models
    logic [7:0]  mem    [0:4095];
    logic [7:0]  wr_mem [0:4095];
    int          wr_tag [0:4095];
    int          hs_addr[0:16383];
    logic [15:0] got    [0:4095];
    int          epoch = 1;
    int          n_mem = 0, n_rd = 0, n_wr = 0;
    logic        ack_q = 1'b0;
    int          n_chk = 0, n_bad = 0;

    function automatic logic [15:0] dw(input int k);
        return 16'(k * 313 + 'h5A3C) ^ 16'h0F0F;
    endfunction

    assign mem_ack   = ack_q;
    assign mem_rdata = mem[mem_addr[11:0]];
    assign drv_rdata = dw(n_rd);

    always @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= mem_req && !ack_q && (($urandom % 4) != 0);
        if (mem_req && mem_ack) begin
            hs_addr[n_mem % 16384] <= mem_addr;
            n_mem <= n_mem + 1;
            if (mem_we) begin
                wr_mem[mem_addr[11:0]] <= mem_wdata;
                wr_tag[mem_addr[11:0]] <= epoch;
            end
        end
        if (drv_rd) n_rd <= n_rd + 1;
        if (drv_wr) begin
            got[n_wr % 4096] <= drv_wdata;
            n_wr <= n_wr + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int off, input logic [31:0] data, input logic [3:0] be);
        @(negedge clk);
        reg_off = OFF_W'(off); reg_wdata = data; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_off = '0;
    endtask

    task automatic rd(input int off, output logic [31:0] data);
        @(negedge clk);
        reg_off = OFF_W'(off);
        #1 data = reg_rdata;
        reg_off = '0;
    endtask

    // build a table at tbl with nd entries, run it, check everything
    task automatic run_xfer(input bit tomem, input int nd, input int tbl, input int zmask);
        int ra[6]; int rl[6]; int pa[0:2047];
        int total; int n0, r0, w0, t, bad, sn_m, sn_r, sn_w;
        logic [31:0] v; logic [7:0] lenf; logic [31:0] af;
        total = 0;
        for (int i = 0; i < nd; i++) begin
            ra[i] = 'h400 + i * 'h200 + 2 * ($urandom % 8);
            lenf  = ((zmask >> i) & 1) ? 8'h00 : 8'(2 * (1 + $urandom % 127));
            lenf  = lenf | 8'($urandom % 2);
            rl[i] = ((lenf & 8'hFE) == 0) ? 256 : int'(lenf & 8'hFE);
            af    = 32'(ra[i]) | 32'($urandom % 2);
            for (int b = 0; b < 4; b++) mem[tbl + 8*i + b] = af[8*b +: 8];
            mem[tbl + 8*i + 4] = lenf;
            mem[tbl + 8*i + 5] = 8'h00;
            mem[tbl + 8*i + 6] = 8'($urandom);
            mem[tbl + 8*i + 7] = ((i == nd - 1) ? 8'h80 : 8'h00) | 8'($urandom % 128);
            for (int j = 0; j < rl[i]; j++) begin
                pa[total + j] = ra[i] + j;
                if (!tomem) mem[ra[i] + j] = 8'($urandom);
            end
            total += rl[i];
        end
        epoch++;
        wr(0, tomem ? 32'h8 : 32'h0, 4'b0001);
        wr(1, 32'(tbl), 4'b1111);
        n0 = n_mem; r0 = n_rd; w0 = n_wr;
        wr(0, tomem ? 32'h9 : 32'h1, 4'b0001);
        t = 0;
        do begin
            @(negedge clk);
            dmarq = (($urandom % 3) != 0);
            reg_off = '0;
            #1 t++;
        end while (reg_rdata[16] && t < 40000);
        chk("R10 run flag cleared at end of table", {31'b0, reg_rdata[16]}, 32'd0);
        // overrun: request stays high after the last word
        dmarq = 1'b1;
        sn_m = n_mem; sn_r = n_rd; sn_w = n_wr;
        tick(30);
        chk("R10 no access after end of table", n_mem + n_rd + n_wr, sn_m + sn_r + sn_w);
        rd(0, v);
        chk("R10 run and error bits after overrun", {30'b0, v[17:16]}, 32'd0);
        chk("R5 R9 memory accesses = 8 per entry + bytes", n_mem - n0, nd * 8 + total);
        chk("R2 first access at table base", hs_addr[n0 % 16384], 32'(tbl));
        for (int i = 0; i < nd * 8; i++)
            if (hs_addr[(n0 + i) % 16384] != 32'(tbl + i)) bad++;
        if (tomem) begin
            chk("R8 drive word reads", n_rd - r0, total / 2);
            bad = 0;
            for (int p = 0; p < total; p++) begin
                logic [15:0] w; logic [7:0] eb;
                w  = dw(r0 + p / 2);
                eb = (p % 2) ? w[15:8] : w[7:0];
                if (wr_tag[pa[p]] != epoch || wr_mem[pa[p]] !== eb) bad++;
            end
            chk("R8 R5 R6 bytes written to memory", bad, 0);
            bad = 0;
            for (int i = 0; i < nd; i++)
                if (wr_tag[ra[i] + rl[i]] == epoch || wr_tag[ra[i] - 1] == epoch) bad++;
            chk("R5 R6 no write outside buffers", bad, 0);
        end else begin
            chk("R8 drive word writes", n_wr - w0, total / 2);
            bad = 0;
            for (int j = 0; j < total / 2; j++)
                if (got[(w0 + j) % 4096] !== {mem[pa[2*j+1]], mem[pa[2*j]]}) bad++;
            chk("R8 R5 R6 words delivered to drive", bad, 0);
        end
        dmarq = 1'b0;
        wr(0, 32'h0, 4'b0001);
    endtask

    task automatic main_seq();
        logic [31:0] v;
        int sn;
        void'($urandom(32'h5EED_0042));
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // reset state
        rd(0, v); chk("R1 command/status after reset", v, 32'h0);
        rd(1, v); chk("R11 base after reset", v, 32'h0);
        rd(2, v); chk("R11 offset 2 reads all ones", v, 32'hFFFF_FFFF);
        rd(3, v); chk("R11 offset 3 reads all ones", v, 32'hFFFF_FFFF);

        // R1: only start and direction kept
        wr(0, 32'hFFFF_FFFE, 4'b0001);
        rd(0, v); chk("R1 command keeps bit 3 only", v, 32'h0000_0008);

        // R13 / R4: byte lanes and status bits
        wr(0, 32'h0060_0000, 4'b0001);
        rd(0, v); chk("R13 byte 0 write leaves status", v, 32'h0000_0000);
        wr(0, 32'hFFFF_FFFF, 4'b0100);
        rd(0, v); chk("R4 R13 status write sets only bits 5,6", v, 32'h0060_0000);
        wr(0, 32'h0000_0008, 4'b0001);
        rd(0, v); chk("R13 command write keeps capability bits", v, 32'h0060_0008);
        wr(0, 32'h0000_0000, 4'b0100);
        wr(0, 32'h0000_0000, 4'b0001);
        rd(0, v); chk("R4 capability bits cleared by write", v, 32'h0);

        // R12: interrupt on rising edge, W1C
        @(negedge clk) drv_irq = 1'b1;
        tick(2);
        rd(0, v); chk("R12 rising edge sets interrupt bit", v, 32'h0004_0000);
        wr(0, 32'h0004_0000, 4'b0100);
        tick(3);
        rd(0, v); chk("R4 R12 write one clears, held level ignored", v, 32'h0);
        @(negedge clk) drv_irq = 1'b0;
        tick(2);
        @(negedge clk) drv_irq = 1'b1;
        tick(1);
        @(negedge clk) drv_irq = 1'b0;
        wr(0, 32'h0000_0000, 4'b0100);
        rd(0, v); chk("R4 write zero keeps interrupt bit", v, 32'h0004_0000);
        wr(0, 32'h0004_0000, 4'b0100);

        // R11: base register
        wr(1, 32'h1234_5677, 4'b1111);
        rd(1, v); chk("R11 base low bits forced zero", v, 32'h1234_5674);
        wr(1, 32'h0000_AB03, 4'b0010);
        rd(1, v); chk("R11 base byte enable", v, 32'h1234_AB74);

        // R7: no activity without request
        wr(1, 32'h100, 4'b1111);
        sn = n_mem + n_rd + n_wr;
        wr(0, 32'h9, 4'b0001);
        tick(40);
        chk("R7 no access while request low", n_mem + n_rd + n_wr, sn);
        rd(0, v); chk("R2 run flag set by start", {31'b0, v[16]}, 32'd1);
        wr(0, 32'h8, 4'b0001);
        rd(0, v); chk("R3 stop clears run flag", {31'b0, v[16]}, 32'd0);

        // directed transfers
        run_xfer(1'b1, 3, 'h100, 0);
        run_xfer(1'b0, 4, 'h180, 0);
        run_xfer(1'b1, 1, 'h200, 1);
        run_xfer(1'b0, 2, 'h240, 1);

        // R3: abort mid-transfer, then restart from a new base (R2)
        for (int b = 0; b < 8; b++) mem['h2C0 + b] = 8'h00;
        mem['h2C0] = 8'h00; mem['h2C1] = 8'h06;  // buffer at 0x600
        mem['h2C7] = 8'h80;                      // count 0 -> 256, final
        wr(1, 32'h2C0, 4'b1111);
        wr(0, 32'h1, 4'b0001);
        @(negedge clk) dmarq = 1'b1;
        tick(100);
        wr(0, 32'h0, 4'b0001);
        rd(0, v); chk("R3 abort clears run flag", {31'b0, v[16]}, 32'd0);
        sn = n_mem + n_rd + n_wr;
        tick(40);
        chk("R3 no access after abort", n_mem + n_rd + n_wr, sn);
        dmarq = 1'b0;
        run_xfer(1'b1, 5, 'h300, 5'b00100);

        // random mix
        for (int k = 0; k < 4; k++)
            run_xfer(1'($urandom % 2), 1 + int'($urandom % 5), 'h100 + 'h40 * k, int'($urandom % 32));
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=expired expected=completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule